// File: doc/BRIEF.md
# Spreading-Code Pilot Correlator with Adaptive Peak Detection

This block performs coarse timing for a direct-sequence spread-spectrum receiver. Each chip period it accepts one signed I sample and one signed Q sample. It correlates each rail against a fixed pilot spreading code of parameter length. The code is a parameter of the block. Each correlator is a transposed-form filter whose taps only add or subtract the incoming sample, so no multipliers are needed. The block squares and sums the two correlator outputs to obtain a correlation power. It also keeps a running strength estimate by averaging the squared absolute-sum of the correlator outputs.

Two thresholds are derived from the strength estimate with shifts and adds, one above it and one just over it. A correlation peak is flagged when the power clears the upper threshold and beats every value seen since the power last dropped under the lower threshold. A pilot is reported once several peaks arrive exactly one code period apart. Downstream logic uses the peak flag to place the symbol strobe and uses the pilot flag to leave the search mode.

Top module: `pn_pilot_correlator`

## Requirements
- R1: While `rst` is high and on the cycle after it is released, `out_valid`, `peak`, `pilot`, `mag` and `strength` are all zero, and every correlator tap holds zero.
- R2: After a sample n is accepted, the correlation on each rail equals the sum over j = 0..L-1 of w(j)·x[n-L+1+j], where L = CODE_LEN and w(j) = +1 if bit j of CODE is 1 and -1 if it is 0. Bit 0 therefore weights the oldest sample. Samples not yet received count as zero.
- R3: `mag` equals I_corr² + Q_corr² for the sample it belongs to, as an unsigned value twice the correlator width wide.
- R4: With s = (|I_corr| + |Q_corr|)², each accepted sample updates the strength estimate a as a ← a + floor((s − a) / 8). `strength` shows a after that update and changes on no other cycle.
- R5: The upper threshold is a + (a>>1) + (a>>2), and the lower threshold is a + (a>>4) + (a>>5). Both use the value of a before the current sample's update.
- R6: `peak` is 1 for a sample exactly when its power is not below the lower threshold, is strictly above the upper threshold, and is strictly above the running maximum. The running maximum is cleared to 0 by any sample whose power is below the lower threshold. Otherwise it takes the larger of itself and the power. It updates on every accepted sample, including those before `out_valid` starts.
- R7: `pilot` rises on the output where the PEAKS_NEEDED-th peak in a row arrives exactly CODE_LEN outputs after the previous one. It stays high while peaks keep that spacing. It falls when an output CODE_LEN after the last peak carries no peak, or when a peak arrives at any other spacing.
- R8: `out_valid` pulses high two clock cycles after a sample is accepted. It stays low until CODE_LEN samples have been accepted. `mag`, `strength`, `peak` and `pilot` are valid while it is high.
- R9: Cycles with `in_valid` low leave every internal state unchanged, whatever `in_i` and `in_q` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Chip sample strobe |
| in_i | input | SAMPLE_W | Signed in-phase chip sample |
| in_q | input | SAMPLE_W | Signed quadrature chip sample |
| out_valid | output | 1 | Result strobe |
| peak | output | 1 | Correlation peak flag |
| pilot | output | 1 | Pilot detected level |
| mag | output | 2*(SAMPLE_W+clog2(CODE_LEN)) | Correlation power |
| strength | output | 2*(SAMPLE_W+clog2(CODE_LEN)) | Running strength estimate |

## Verification
The bench sends clean pilot trains at the positive and negative full-scale extremes. A design with a wrong chip order or a tap sign error would then report a power far below 2·(31·64)², or would miss the sign extension of −64. Idle gaps with random data on the inputs catch a design that clocks its taps or its average without `in_valid`; such a design shows wrong powers and strengths on the next output. Noisy trains drive the peak and pilot logic through missed peaks and off-spacing peaks. Off-by-one errors in the threshold comparisons, in the maximum reset or in the spacing count then show up as a wrong `peak` or `pilot` bit. The first 30 samples check that `out_valid` does not rise early.

// File: rtl/pnc_pkg.sv
package pnc_pkg;
  // Correlator accumulator width: sample width plus growth over the code length
  function automatic int acc_width(input int sample_w, input int code_len);
    return sample_w + $clog2(code_len);
  endfunction
endpackage

// File: rtl/pnc_tap_chain.sv
module pnc_tap_chain #(
  parameter int SW = 7,
  parameter int LEN = 31,
  parameter logic [LEN-1:0] CODE = '1,
  parameter int AW = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [SW-1:0] x,
  output logic signed [AW-1:0] sum_next,
  output logic signed [AW-1:0] sum_q
);
  localparam int LIMIT = LEN * (2 ** (SW - 1));

  logic signed [AW-1:0] xp, xn;
  logic signed [AW-1:0] stg [LEN];
  logic signed [AW-1:0] nxt [LEN];

  assign xp = {{(AW-SW){x[SW-1]}}, x};
  assign xn = -xp;

  // Stage k weights the sample that is k samples old with code bit LEN-1-k
  for (genvar k = 0; k < LEN; k++) begin : g_tap
    if (k == LEN - 1) begin : g_end
      assign nxt[k] = CODE[LEN-1-k] ? xp : xn;
    end else begin : g_mid
      assign nxt[k] = stg[k+1] + (CODE[LEN-1-k] ? xp : xn);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < LEN; k++) stg[k] <= '0;
    end else if (en) begin
      for (int k = 0; k < LEN; k++) stg[k] <= nxt[k];
    end
  end

  assign sum_next = nxt[0];
  assign sum_q    = stg[0];

  // R2
  corr_range_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(sum_q) <= LIMIT) && (int'(sum_q) >= -LIMIT));
endmodule

// File: rtl/pnc_power.sv
module pnc_power #(
  parameter int AW = 12,
  parameter int PW = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en1,
  input  logic                 en2,
  input  logic signed [AW-1:0] ci,
  input  logic signed [AW-1:0] cq,
  output logic [PW-1:0]        pwr_q,
  output logic [PW-1:0]        avg_q,
  output logic [PW:0]          hi,
  output logic [PW:0]          lo
);
  logic [AW-1:0]        ai, aq;
  logic [AW:0]          asum;
  logic [PW-1:0]        sq_q;
  logic signed [PW+1:0] diff, step;

  assign ai   = ci[AW-1] ? AW'(-ci) : AW'(ci);
  assign aq   = cq[AW-1] ? AW'(-cq) : AW'(cq);
  assign asum = {1'b0, ai} + {1'b0, aq};

  assign diff = signed'({2'b00, sq_q}) - signed'({2'b00, avg_q});
  assign step = diff >>> 3;

  assign hi = {1'b0, avg_q} + {2'b00, avg_q[PW-1:1]} + {3'b000, avg_q[PW-1:2]};
  assign lo = {1'b0, avg_q} + {5'b00000, avg_q[PW-1:4]} + {6'b000000, avg_q[PW-1:5]};

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_q <= '0;
      sq_q  <= '0;
      avg_q <= '0;
    end else begin
      if (en1) begin
        pwr_q <= PW'(ai) * PW'(ai) + PW'(aq) * PW'(aq);
        sq_q  <= PW'(asum) * PW'(asum);
      end
      if (en2) avg_q <= PW'(signed'({2'b00, avg_q}) + step);
    end
  end

  // R4
  avg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en2 |=> $stable(avg_q));
endmodule

// File: rtl/pnc_peak.sv
module pnc_peak #(
  parameter int PW = 24,
  parameter int LEN = 31,
  parameter int PEAKS = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en2,
  input  logic          full,
  input  logic [PW-1:0] pwr,
  input  logic [PW:0]   hi,
  input  logic [PW:0]   lo,
  output logic          out_valid_q,
  output logic          peak_q,
  output logic          pilot_q,
  output logic [PW-1:0] mag_q
);
  localparam int GW = $clog2(LEN + 2);
  localparam int KW = $clog2(PEAKS + 1);

  logic [PW-1:0] mx_q;
  logic [GW-1:0] gap_q, gap_nx;
  logic [KW-1:0] streak_q, streak_nx;
  logic below, over, newmax, pk;

  assign below  = {1'b0, pwr} < lo;
  assign over   = {1'b0, pwr} > hi;
  assign newmax = pwr > mx_q;
  assign pk     = !below && over && newmax;

  always_comb begin
    gap_nx    = gap_q;
    streak_nx = streak_q;
    if (full) begin
      if (pk) begin
        gap_nx = GW'(1);
        if (gap_q == GW'(LEN))
          streak_nx = (streak_q == KW'(PEAKS)) ? streak_q : streak_q + KW'(1);
        else
          streak_nx = KW'(1);
      end else begin
        if (gap_q != GW'(LEN + 1)) gap_nx = gap_q + GW'(1);
        if (gap_q == GW'(LEN)) streak_nx = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_q <= 1'b0;
      peak_q      <= 1'b0;
      pilot_q     <= 1'b0;
      mag_q       <= '0;
      mx_q        <= '0;
      gap_q       <= '0;
      streak_q    <= '0;
    end else begin
      out_valid_q <= en2 && full;
      peak_q      <= en2 && full && pk;
      if (en2) begin
        mx_q     <= below ? '0 : (newmax ? pwr : mx_q);
        mag_q    <= pwr;
        gap_q    <= gap_nx;
        streak_q <= streak_nx;
        pilot_q  <= streak_nx >= KW'(PEAKS);
      end
    end
  end

  // R6
  peak_valid_chk: assert property (@(posedge clk) disable iff (rst)
    peak_q |-> out_valid_q);
  // R7
  pilot_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pilot_q) |-> peak_q);
endmodule

// File: rtl/pn_pilot_correlator.sv
module pn_pilot_correlator #(
  parameter int SAMPLE_W = 7,
  parameter int CODE_LEN = 31,
  parameter logic [CODE_LEN-1:0] CODE = 31'h3C8AD2E7,
  parameter int PEAKS_NEEDED = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] in_i,
  input  logic signed [SAMPLE_W-1:0] in_q,
  output logic                       out_valid,
  output logic                       peak,
  output logic                       pilot,
  output logic [2*(SAMPLE_W+$clog2(CODE_LEN))-1:0] mag,
  output logic [2*(SAMPLE_W+$clog2(CODE_LEN))-1:0] strength
);
  import pnc_pkg::*;
  localparam int AW = acc_width(SAMPLE_W, CODE_LEN);
  localparam int PW = 2 * AW;
  localparam int CW = $clog2(CODE_LEN + 1);

  logic signed [AW-1:0] ci_nx, cq_nx, ci_q, cq_q;
  logic [PW-1:0] pwr_q, avg_q;
  logic [PW:0]   hi, lo;
  logic [CW-1:0] cnt_q;
  logic          v1_q, full1_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      v1_q    <= 1'b0;
      full1_q <= 1'b0;
    end else begin
      v1_q <= in_valid;
      if (in_valid) begin
        full1_q <= cnt_q >= CW'(CODE_LEN - 1);
        if (cnt_q != CW'(CODE_LEN)) cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  pnc_tap_chain #(.SW(SAMPLE_W), .LEN(CODE_LEN), .CODE(CODE), .AW(AW)) u_chain_i (
    .clk(clk), .rst(rst), .en(in_valid), .x(in_i), .sum_next(ci_nx), .sum_q(ci_q));
  pnc_tap_chain #(.SW(SAMPLE_W), .LEN(CODE_LEN), .CODE(CODE), .AW(AW)) u_chain_q (
    .clk(clk), .rst(rst), .en(in_valid), .x(in_q), .sum_next(cq_nx), .sum_q(cq_q));

  pnc_power #(.AW(AW), .PW(PW)) u_power (
    .clk(clk), .rst(rst), .en1(in_valid), .en2(v1_q), .ci(ci_nx), .cq(cq_nx),
    .pwr_q(pwr_q), .avg_q(avg_q), .hi(hi), .lo(lo));

  pnc_peak #(.PW(PW), .LEN(CODE_LEN), .PEAKS(PEAKS_NEEDED)) u_peak (
    .clk(clk), .rst(rst), .en2(v1_q), .full(full1_q), .pwr(pwr_q), .hi(hi), .lo(lo),
    .out_valid_q(out_valid), .peak_q(peak), .pilot_q(pilot), .mag_q(mag));

  assign strength = avg_q;

  // R8
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));
  // R5
  peak_level_chk: assert property (@(posedge clk) disable iff (rst)
    peak |-> ({1'b0, mag} > {1'b0, $past(strength)}));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(ci_q) && $stable(cq_q)));
endmodule

// File: tb/pn_pilot_correlator_tb.sv
module pn_pilot_correlator_tb;
  localparam int SW = 7;
  localparam int L = 31;
  localparam logic [L-1:0] CODE = 31'h3C8AD2E7;
  localparam int PK = 3;
  localparam int PW = 2 * (SW + $clog2(L));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [SW-1:0] in_i = '0, in_q = '0;
  logic out_valid, peak, pilot;
  logic [PW-1:0] mag, strength;

  always #2 clk = ~clk;

  pn_pilot_correlator #(.SAMPLE_W(SW), .CODE_LEN(L), .CODE(CODE), .PEAKS_NEEDED(PK)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .peak(peak), .pilot(pilot), .mag(mag), .strength(strength));

  typedef struct {
    longint due;
    longint pwr;
    longint avg;
    bit     pk;
    bit     pil;
  } exp_t;

  exp_t   expq[$];
  int     checks = 0, fails = 0;
  longint cyc = 0;
  bit     done = 0;

  longint hi_i[L], hi_q[L];
  longint m_avg = 0, m_mx = 0;
  int     m_gap = 0, m_streak = 0, m_cnt = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint corr(input longint h[L]);
    longint s = 0;
    for (int a = 0; a < L; a++) s += CODE[L-1-a] ? h[a] : -h[a];
    return s;
  endfunction

  function automatic longint labs(input longint v);
    return v < 0 ? -v : v;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, expv, cyc);
    end
  endtask

  // Reference model, advanced once per accepted sample
  task automatic model(input longint xi, input longint xq);
    longint ci, cq, pw, s, hv, lv;
    bit below, pk;
    exp_t e;
    for (int a = L - 1; a > 0; a--) begin
      hi_i[a] = hi_i[a-1];
      hi_q[a] = hi_q[a-1];
    end
    hi_i[0] = xi;
    hi_q[0] = xq;
    ci = corr(hi_i);
    cq = corr(hi_q);
    pw = ci * ci + cq * cq;
    s  = (labs(ci) + labs(cq)) * (labs(ci) + labs(cq));
    hv = m_avg + (m_avg >> 1) + (m_avg >> 2);
    lv = m_avg + (m_avg >> 4) + (m_avg >> 5);
    below = pw < lv;
    pk = !below && (pw > hv) && (pw > m_mx);
    m_mx = below ? 0 : (pw > m_mx ? pw : m_mx);
    m_avg = m_avg + ((s - m_avg) >>> 3);
    if (m_cnt < L) m_cnt++;
    if (m_cnt >= L) begin
      if (pk) begin
        m_streak = (m_gap == L) ? (m_streak == PK ? PK : m_streak + 1) : 1;
        m_gap = 1;
      end else begin
        if (m_gap == L) m_streak = 0;
        if (m_gap != L + 1) m_gap++;
      end
      e.due = cyc + 2;
      e.pwr = pw;
      e.avg = m_avg;
      e.pk  = pk;
      e.pil = m_streak >= PK;
      expq.push_back(e);
    end
  endtask

  task automatic send(input int xi, input int xq);
    @(negedge clk);
    in_i = SW'(xi);
    in_q = SW'(xq);
    in_valid = 1'b1;
    model(xi, xq);
  endtask

  // R9: idle cycles carry random garbage that must be ignored
  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_i = SW'($urandom);
      in_q = SW'($urandom);
    end
  endtask

  function automatic int noise(input int amp);
    return int'($urandom_range(0, 2 * amp)) - amp;
  endfunction

  function automatic int clip(input int v);
    return v > 63 ? 63 : (v < -64 ? -64 : v);
  endfunction

  task automatic train(input int amp, input int nz, input int reps, input bit gaps);
    for (int r = 0; r < reps; r++)
      for (int j = 0; j < L; j++) begin
        send(clip((CODE[j] ? amp : -amp) + noise(nz)),
             clip((CODE[j] ? amp : -amp) + noise(nz)));
        if (gaps && ($urandom_range(0, 3) == 0)) idle($urandom_range(1, 3));
      end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      bit due_now;
      due_now = (expq.size() > 0) && (expq[0].due == cyc);
      // R8: strobe timing and the 31-sample fill
      check(out_valid == due_now, "R8 out_valid", out_valid, due_now);
      if (due_now) begin
        exp_t e;
        e = expq.pop_front();
        check(longint'(mag) == e.pwr, "R2 R3 R9 mag", mag, e.pwr);
        check(longint'(strength) == e.avg, "R4 strength", strength, e.avg);
        check(peak == e.pk, "R5 R6 peak", peak, e.pk);
        check(pilot == e.pil, "R7 pilot", pilot, e.pil);
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int a = 0; a < L; a++) begin
      hi_i[a] = 0;
      hi_q[a] = 0;
    end
    repeat (4) @(negedge clk);
    // R1: reset state
    check(out_valid == 0 && peak == 0 && pilot == 0, "R1 flags", {out_valid, peak, pilot}, 0);
    check(mag == 0 && strength == 0, "R1 values", mag + strength, 0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 0 && mag == 0 && strength == 0, "R1 after release", mag, 0);

    // Random noise only, with gaps
    for (int n = 0; n < 400; n++) begin
      send(noise(64) < 64 ? noise(63) : 0, noise(63));
      if ($urandom_range(0, 4) == 0) idle($urandom_range(1, 4));
    end
    // Clean full-scale negative and positive pilot trains
    train(-64, 0, 4, 1'b0);
    idle(7);
    train(63, 0, 4, 1'b1);
    // Noise then noisy pilots, a broken train, and more pilots
    for (int n = 0; n < 200; n++) send(noise(20), noise(20));
    train(30, 12, 5, 1'b1);
    for (int n = 0; n < 45; n++) send(noise(30), noise(30));
    train(40, 20, 4, 1'b0);
    train(12, 40, 3, 1'b1);
    for (int n = 0; n < 300; n++) send(noise(63), noise(63));
    idle(6);
    check(expq.size() == 0, "R8 all outputs seen", expq.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule